// File: doc/BRIEF.md
# Latched Interrupt Pending Controller

This block collects interrupt requests from a parameterised number of external lines and a small group of internal exception sources. It holds each one in a pending bit until it is serviced. It then offers the core the most urgent pending source that is enabled. External lines are asynchronous, so each one passes through a synchronizer. Only the rising edge of the synchronized line sets its pending bit. Once set, the bit stays set after the line drops.

When the core accepts an offered source, the block clears that source's pending bit and makes its exception number the active number. It saves the previous number on a small internal stack. An exception-return strobe brings the saved number back. Internal sources take numbers starting at 2. External line `j` has number `16 + j`. The active-number field reads zero when nothing is being serviced.

A word-wide register port gives access to the enables, the priority levels and the pending bits, and lets software set or clear individual pending bits. Some internal sources can be marked critical by a parameter. A critical source cannot be masked. It outranks every configurable level, so it is taken at once unless another critical source is active.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, `active_num` is 0, `irq_valid` is 0, and the enable register (address 0), the pending registers (addresses 1 and 2) and the status register (address 3) all read 0.
- R2: A rising edge on `ext_irq[j]` sets pending bit `j`, which reads at bit `j` of address 1. The bit stays set after the line falls. When this source is offered, `irq_num` is `16 + j`.
- R3: A pending source whose enable bit is 0 is not offered and stays pending. Setting its enable bit makes it offered. External enables are at address 0, bit `j`. Internal enables are at address 4, bit `i`.
- R4: Among the eligible sources, the one with the lowest priority value is offered. If two have the same value, the one with the lower exception number is offered.
- R5: A source is offered only if its level is strictly more urgent than the active level. The active level is least urgent when `active_num` is 0. An equal level stays pending.
- R6: When `irq_accept` is high while `irq_valid` is high and `exc_return` is low, the next cycle shows `irq_num` as `active_num`, and that source's pending bit is cleared.
- R7: An `exc_return` pulse restores the active number that was in force before the most recent accept. After the outermost return, it reads 0.
- R8: Writing address 1 sets the external pending bits that are 1 in the write data. Writing address 2 clears them. Bits written as 0 are unchanged. The change reads back in the cycle after the write.
- R9: A critical internal source (bit `i` of `CRIT_MASK` set; the default is source 0, number 2) is offered even when its enable bit is 0. It is offered even while a non-critical source is active at the most urgent level.
- R10: A one-cycle pulse on `sys_req[i]` sets the pending bit of internal source `i`, which reads at address 3 bit `16 + i`. Address 3 bits [7:0] hold `active_num`. When offered, the source's number is `2 + i`.
- R11: Each priority field is 3 bits wide and sits in a 4-bit nibble. External source `j` uses address `8 + j/8`, nibble `j%8`. Internal source `i` uses address 5, nibble `i`. The top bit of each nibble reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | N_EXT | Asynchronous external request lines |
| sys_req | input | N_SYS | Single-cycle internal exception requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq_valid | output | 1 | A source is offered to the core |
| irq_num | output | 8 | Exception number offered (0 when none) |
| irq_accept | input | 1 | Core takes the offered source |
| exc_return | input | 1 | Core leaves the active handler |
| active_num | output | 8 | Exception number being serviced (0 when idle) |

## Verification
The bench targets equal priority levels. It checks that a tie is broken by the lower number. A design that compared with less-or-equal would pick the higher number instead. It also checks that a source at the active level is not taken, which a non-strict comparison would wrongly allow. A request line is pulsed and then dropped before the enable is set, to show that the pending bit holds. A design that sampled the level directly would lose the request. Nested accepts and returns confirm that the stack brings back the right outer number and then zero. A critical source is raised while its enable is clear and a level-0 handler is active. A design that masked it, or ranked it with the ordinary levels, would leave it waiting.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NUM_W    = 8;
   localparam int SYS_BASE = 2;
   localparam int EXT_BASE = 16;
   localparam int ADDR_W   = 4;
   localparam int DATA_W   = 32;

   typedef logic [NUM_W-1:0] exc_num_t;

   localparam logic [ADDR_W-1:0] A_ENABLE   = 4'd0;
   localparam logic [ADDR_W-1:0] A_SETPEND  = 4'd1;
   localparam logic [ADDR_W-1:0] A_CLRPEND  = 4'd2;
   localparam logic [ADDR_W-1:0] A_STATUS   = 4'd3;
   localparam logic [ADDR_W-1:0] A_SYSCTL   = 4'd4;
   localparam logic [ADDR_W-1:0] A_SYSPRIO  = 4'd5;
   localparam logic [ADDR_W-1:0] A_EXTPRIO0 = 4'd8;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] a_in,
   output logic [N-1:0] rise
);
   localparam int SR_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync_edge: STAGES must be at least 2");
   end

   for (genvar b = 0; b < N; b++) begin : g_line
      logic [SR_W-1:0] sr_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sr_q <= '0;
         else        sr_q <= {sr_q[SR_W-2:0], a_in[b]};
      end
      assign rise[b] = sr_q[SR_W-2] & ~sr_q[SR_W-1];
   end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
   parameter int NSRC  = 36,
   parameter int EFF_W = 4,
   parameter int IDX_W = 6
) (
   input  logic [NSRC-1:0]            elig,
   input  logic [NSRC-1:0][EFF_W-1:0] eff,
   output logic                       found,
   output logic [IDX_W-1:0]           idx,
   output logic [EFF_W-1:0]           best
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '1;
      for (int i = 0; i < NSRC; i++) begin
         if (elig[i] && (!found || (eff[i] < best))) begin
            found = 1'b1;
            best  = eff[i];
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
   parameter int DEPTH = 9,
   parameter int NUM_W = 8,
   parameter int EFF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [NUM_W-1:0] push_num,
   input  logic [EFF_W-1:0] push_eff,
   output logic [NUM_W-1:0] act_num,
   output logic [EFF_W-1:0] act_eff
);
   localparam int SP_W = $clog2(DEPTH + 1);

   logic [DEPTH-1:0][NUM_W-1:0] num_stk;
   logic [DEPTH-1:0][EFF_W-1:0] eff_stk;
   logic [SP_W-1:0]             sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q    <= '0;
         act_num <= '0;
         act_eff <= '1;
      end else if (pop) begin
         if (sp_q != '0) begin
            sp_q    <= sp_q - 1'b1;
            act_num <= num_stk[sp_q - 1'b1];
            act_eff <= eff_stk[sp_q - 1'b1];
         end else begin
            act_num <= '0;
            act_eff <= '1;
         end
      end else if (push && (sp_q < SP_W'(DEPTH))) begin
         sp_q    <= sp_q + 1'b1;
         act_num <= push_num;
         act_eff <= push_eff;
      end
   end

   always_ff @(posedge clk) begin
      if (!pop && push && (sp_q < SP_W'(DEPTH))) begin
         num_stk[sp_q] <= act_num;
         eff_stk[sp_q] <= act_eff;
      end
   end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
   import irq_pkg::*;
#(
   parameter int         N_EXT       = 32,
   parameter int         N_SYS       = 4,
   parameter logic [7:0] CRIT_MASK   = 8'h01,
   parameter int         PRIO_W      = 3,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_EXT-1:0]    ext_irq,
   input  logic [N_SYS-1:0]    sys_req,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq_valid,
   output logic [NUM_W-1:0]    irq_num,
   input  logic                irq_accept,
   input  logic                exc_return,
   output logic [NUM_W-1:0]    active_num
);
   localparam int NSRC  = N_SYS + N_EXT;
   localparam int IDX_W = $clog2(NSRC);
   localparam int EFF_W = PRIO_W + 1;
   localparam int STK_D = (1 << PRIO_W) + 1;

   if (N_EXT < 1 || N_EXT > 32) begin : g_bad_ext
      $error("irq_pend_ctrl: N_EXT must be 1..32");
   end
   if (N_SYS < 1 || N_SYS > 8) begin : g_bad_sys
      $error("irq_pend_ctrl: N_SYS must be 1..8");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("irq_pend_ctrl: PRIO_W must be 1..4");
   end

   logic [N_EXT-1:0]             en_ext_q;
   logic [N_SYS-1:0]             en_sys_q;
   logic [N_EXT-1:0][PRIO_W-1:0] prio_ext_q;
   logic [N_SYS-1:0][PRIO_W-1:0] prio_sys_q;
   logic [NSRC-1:0]              pend_q;

   logic [N_EXT-1:0]             ext_rise;
   logic [NSRC-1:0]              en_all;
   logic [NSRC-1:0][EFF_W-1:0]   eff_all;
   logic [NSRC-1:0][NUM_W-1:0]   num_all;
   logic [NSRC-1:0]              elig;
   logic                         sel_found;
   logic [IDX_W-1:0]             sel_idx;
   logic [EFF_W-1:0]             sel_eff;
   logic [EFF_W-1:0]             act_eff;
   logic                         take;
   logic [NSRC-1:0]              take_clr;
   logic [NSRC-1:0]              sw_set;
   logic [NSRC-1:0]              sw_clr;

   irq_sync_edge #(.N(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .a_in (ext_irq),
      .rise (ext_rise)
   );

   // Per-source urgency, enable and number
   for (genvar i = 0; i < N_SYS; i++) begin : g_sys
      if (CRIT_MASK[i]) begin : g_crit
         assign eff_all[i] = '0;
         assign en_all[i]  = 1'b1;
      end else begin : g_norm
         assign eff_all[i] = EFF_W'(prio_sys_q[i]) + 1'b1;
         assign en_all[i]  = en_sys_q[i];
      end
      assign num_all[i] = NUM_W'(SYS_BASE + i);
   end
   for (genvar j = 0; j < N_EXT; j++) begin : g_ext
      assign eff_all[N_SYS+j] = EFF_W'(prio_ext_q[j]) + 1'b1;
      assign en_all[N_SYS+j]  = en_ext_q[j];
      assign num_all[N_SYS+j] = NUM_W'(EXT_BASE + j);
   end

   for (genvar k = 0; k < NSRC; k++) begin : g_elig
      assign elig[k] = pend_q[k] & en_all[k] & (eff_all[k] < act_eff);
   end

   irq_select #(.NSRC(NSRC), .EFF_W(EFF_W), .IDX_W(IDX_W)) u_sel (
      .elig (elig),
      .eff  (eff_all),
      .found(sel_found),
      .idx  (sel_idx),
      .best (sel_eff)
   );

   assign irq_valid = sel_found;
   assign irq_num   = sel_found ? num_all[sel_idx] : '0;
   assign take      = irq_accept & sel_found & ~exc_return;

   always_comb begin
      take_clr = '0;
      if (take) take_clr[sel_idx] = 1'b1;
      sw_set = '0;
      sw_clr = '0;
      if (reg_we && reg_addr == A_SETPEND) sw_set[N_SYS +: N_EXT] = reg_wdata[N_EXT-1:0];
      if (reg_we && reg_addr == A_CLRPEND) sw_clr[N_SYS +: N_EXT] = reg_wdata[N_EXT-1:0];
   end

   // Pending latches: new requests win over clears in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~take_clr & ~sw_clr) | {ext_rise, sys_req} | sw_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_ext_q <= '0;
         en_sys_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == A_ENABLE) en_ext_q <= reg_wdata[N_EXT-1:0];
         if (reg_addr == A_SYSCTL) en_sys_q <= reg_wdata[N_SYS-1:0];
      end
   end

   for (genvar j = 0; j < N_EXT; j++) begin : g_eprio
      always_ff @(posedge clk) begin
         if (!rst_n) prio_ext_q[j] <= '0;
         else if (reg_we && reg_addr == A_EXTPRIO0 + ADDR_W'(j / 8))
            prio_ext_q[j] <= reg_wdata[(j % 8) * 4 +: PRIO_W];
      end
   end
   for (genvar i = 0; i < N_SYS; i++) begin : g_sprio
      always_ff @(posedge clk) begin
         if (!rst_n) prio_sys_q[i] <= '0;
         else if (reg_we && reg_addr == A_SYSPRIO)
            prio_sys_q[i] <= reg_wdata[i * 4 +: PRIO_W];
      end
   end

   irq_active_stack #(.DEPTH(STK_D), .NUM_W(NUM_W), .EFF_W(EFF_W)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (take),
      .pop     (exc_return),
      .push_num(irq_num),
      .push_eff(sel_eff),
      .act_num (active_num),
      .act_eff (act_eff)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_ENABLE:  reg_rdata[N_EXT-1:0] = en_ext_q;
         A_SETPEND,
         A_CLRPEND: reg_rdata[N_EXT-1:0] = pend_q[N_SYS +: N_EXT];
         A_STATUS: begin
            reg_rdata[NUM_W-1:0]   = active_num;
            reg_rdata[16 +: N_SYS] = pend_q[N_SYS-1:0];
         end
         A_SYSCTL:  reg_rdata[N_SYS-1:0] = en_sys_q;
         A_SYSPRIO: for (int i = 0; i < N_SYS; i++) reg_rdata[i*4 +: PRIO_W] = prio_sys_q[i];
         default: begin
            for (int j = 0; j < N_EXT; j++)
               if (reg_addr == A_EXTPRIO0 + ADDR_W'(j / 8))
                  reg_rdata[(j % 8) * 4 +: PRIO_W] = prio_ext_q[j];
         end
      endcase
   end
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk
   import irq_pkg::*;
#(
   parameter int N_EXT = 32,
   parameter int N_SYS = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    reg_we,
   input logic [ADDR_W-1:0]       reg_addr,
   input logic [DATA_W-1:0]       reg_wdata,
   input logic                    irq_valid,
   input logic [NUM_W-1:0]        irq_num,
   input logic                    irq_accept,
   input logic                    exc_return,
   input logic [NUM_W-1:0]        active_num,
   input logic [N_SYS+N_EXT-1:0]  pend_q
);
   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept && irq_valid && !exc_return) |=> (active_num == $past(irq_num)));

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_accept && !(reg_we && reg_addr == A_CLRPEND)) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   p_swset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_SETPEND) |=>
      ((pend_q[N_SYS +: N_EXT] & $past(reg_wdata[N_EXT-1:0])) == $past(reg_wdata[N_EXT-1:0])));

   p_num_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ((irq_num >= NUM_W'(EXT_BASE) && irq_num < NUM_W'(EXT_BASE + N_EXT)) ||
                     (irq_num >= NUM_W'(SYS_BASE) && irq_num < NUM_W'(SYS_BASE + N_SYS))));
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.N_EXT(N_EXT), .N_SYS(N_SYS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq_valid (irq_valid),
   .irq_num   (irq_num),
   .irq_accept(irq_accept),
   .exc_return(exc_return),
   .active_num(active_num),
   .pend_q    (pend_q)
);

// File: tb/tb_irq_pend_ctrl.sv
`timescale 1ns/100ps
module tb_irq_pend_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ext_irq = '0;
   logic [3:0]  sys_req = '0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_valid;
   logic [7:0]  irq_num;
   logic        irq_accept = 1'b0;
   logic        exc_return = 1'b0;
   logic [7:0]  active_num;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_pend_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .sys_req(sys_req),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_valid(irq_valid), .irq_num(irq_num), .irq_accept(irq_accept),
      .exc_return(exc_return), .active_num(active_num)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_accept();
      @(negedge clk); irq_accept = 1'b1;
      @(negedge clk); irq_accept = 1'b0; #1;
   endtask

   task automatic pulse_return();
      @(negedge clk); exc_return = 1'b1;
      @(negedge clk); exc_return = 1'b0; #1;
   endtask

   function automatic int model_pick(input logic [31:0] pend, input logic [31:0] en,
                                     input logic [3:0][31:0] pw);
      int best = 99;
      int pick = -1;
      for (int j = 0; j < 32; j++) begin
         int p = int'((pw[j/8] >> (4*(j%8))) & 32'h7);
         if (pend[j] && en[j] && p < best) begin best = p; pick = j; end
      end
      return pick;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'hC0FFEE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(active_num == 0, "R1 active_num", active_num, 0);
      chk(irq_valid == 0, "R1 irq_valid", irq_valid, 0);
      rd(4'd0, d); chk(d == 0, "R1 enable", d, 0);
      rd(4'd1, d); chk(d == 0, "R1 pending", d, 0);
      rd(4'd3, d); chk(d == 0, "R1 status", d, 0);

      // R11 priority readback
      wr(4'd8, 32'hFFFF_FFFF);
      rd(4'd8, d); chk(d == 32'h7777_7777, "R11 ext prio", d, 32'h7777_7777);
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd5, d); chk(d == 32'h0000_7777, "R11 sys prio", d, 32'h7777);
      wr(4'd5, 32'h0);
      wr(4'd8, 32'h0000_4000);

      // R2/R3 latched edge, masked
      @(negedge clk); ext_irq[3] = 1'b1;
      repeat (2) @(negedge clk); ext_irq[3] = 1'b0;
      repeat (5) @(negedge clk); #1;
      rd(4'd1, d); chk(d == 32'h8, "R2 sticky pending", d, 32'h8);
      chk(irq_valid == 0, "R3 masked not offered", irq_valid, 0);
      wr(4'd0, 32'h8);
      chk(irq_valid && irq_num == 19, "R3 R2 offered num", irq_num, 19);

      // R6 accept
      pulse_accept();
      chk(active_num == 19, "R6 active", active_num, 19);
      rd(4'd1, d); chk(d == 0, "R6 pending cleared", d, 0);
      rd(4'd3, d); chk(d[7:0] == 19, "R10 status num", d[7:0], 19);

      // R5 strict preemption
      wr(4'd8, 32'h0040_4000);
      wr(4'd0, 32'h28);
      wr(4'd1, 32'h20);
      chk(irq_valid == 0, "R5 equal level held", irq_valid, 0);
      wr(4'd8, 32'h0020_4000);
      chk(irq_valid && irq_num == 21, "R5 more urgent offered", irq_num, 21);
      pulse_accept();
      chk(active_num == 21, "R6 nested active", active_num, 21);
      pulse_return();
      chk(active_num == 19, "R7 restore outer", active_num, 19);
      pulse_return();
      chk(active_num == 0, "R7 back to idle", active_num, 0);
      chk(irq_valid == 0, "R7 nothing pending", irq_valid, 0);

      // R4 selection and tie
      wr(4'd8, 32'h1100_0000);
      wr(4'd0, 32'hC0);
      wr(4'd1, 32'hC0);
      chk(irq_valid && irq_num == 22, "R4 tie lower number", irq_num, 22);
      wr(4'd8, 32'h1300_0000);
      chk(irq_valid && irq_num == 23, "R4 lower level wins", irq_num, 23);

      // R8 software set/clear
      wr(4'd2, 32'h40);
      rd(4'd1, d); chk(d == 32'h80, "R8 clear one bit", d, 32'h80);
      wr(4'd1, 32'h200);
      rd(4'd1, d); chk(d == 32'h280, "R8 set keeps others", d, 32'h280);
      wr(4'd2, 32'hFFFF_FFFF);
      rd(4'd1, d); chk(d == 0, "R8 clear all", d, 0);

      // R9/R10 internal sources
      wr(4'd0, 32'h8);
      wr(4'd1, 32'h8);
      pulse_accept();
      chk(active_num == 19, "R9 setup active", active_num, 19);
      @(negedge clk); sys_req = 4'b0011;
      @(negedge clk); sys_req = 4'b0000; #1;
      chk(irq_valid && irq_num == 2, "R9 critical preempts", irq_num, 2);
      rd(4'd3, d); chk(d[17:16] == 2'b11, "R10 sys pending", d[17:16], 3);
      pulse_accept();
      chk(active_num == 2, "R9 critical active", active_num, 2);
      chk(irq_valid == 0, "R3 sys masked", irq_valid, 0);
      wr(4'd4, 32'h2);
      chk(irq_valid == 0, "R5 sys below critical", irq_valid, 0);
      pulse_return();
      chk(irq_valid == 0, "R5 sys equal to active", irq_valid, 0);
      pulse_return();
      chk(irq_valid && irq_num == 3, "R10 sys number", irq_num, 3);
      pulse_accept();
      pulse_return();
      chk(active_num == 0, "R7 idle again", active_num, 0);
      wr(4'd4, 32'h0);

      // Random phase: R4 R8 against model
      for (int it = 0; it < 40; it++) begin
         logic [31:0] en, sp;
         logic [3:0][31:0] pw;
         int exp_pick;
         en = $urandom(); sp = $urandom();
         for (int w = 0; w < 4; w++) begin
            pw[w] = $urandom() & 32'h7777_7777;
            wr(4'(8 + w), pw[w]);
         end
         wr(4'd0, en);
         wr(4'd1, sp);
         rd(4'd1, d); chk(d == sp, "R8 random set", d, sp);
         exp_pick = model_pick(sp, en, pw);
         if (exp_pick < 0) chk(irq_valid == 0, "R4 random none", irq_valid, 0);
         else chk(irq_valid && irq_num == 8'(16 + exp_pick), "R4 random pick", irq_num, 16 + exp_pick);
         wr(4'd2, 32'hFFFF_FFFF);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule